// File: doc/BRIEF.md
# BCD Real-Time Calendar with Shadowed Readout

This block keeps wall-clock time and date as packed BCD. A down-counter divides a prescaled enable (`tick_en`) into seconds. Each time it runs out, a one-second carry ripples through seconds, minutes and hours in 24-hour form, and then through day, month, weekday and a two-digit year.

The day rollover follows the length of each month, and February gains its 29th day when the year field is a multiple of four. The counted values are copied into shadow registers one cycle after every subsecond step, so a reader always sees a consistent time and date together. A ready flag records each refresh, and a bypass input lets reads see the live counters instead.

Software sets the calendar by raising `freeze`, presenting new time and date words on the load port, and dropping `freeze`.

The shadow path is a two-state machine. `SH_IDLE` waits for a subsecond step. The transition `idle_to_capt` is taken when `tick_en` is high and `freeze` is low. In `SH_CAPT` the shadows take the live values and the ready flag is set. The transition `capt_to_idle` is taken when no further step arrives, and `capt_stay` is taken when another step arrives in the same cycle.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, the live and shadow time word is 0x000000, the date word is 0x002101 (day 01, month 01, weekday 1, year 00), the subsecond value is 0 and `rsf` is 0.
- R2: On each cycle with `tick_en`=1 and `freeze`=0, the subsecond counter decrements by one. When it is already 0, it instead reloads `prediv` and advances the seconds by one, so there are `prediv`+1 steps per second.
- R3: The time word layout is: second units [3:0], second tens [6:4], minute units [11:8], minute tens [14:12], hour units [19:16], hour tens [21:20]. Bit 22 (afternoon flag) always reads 0. Seconds and minutes wrap 59→00. Hours count 00..23 and wrap 23→00, producing a day carry.
- R4: On a day carry, the day wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months. February ends at day 29 when the year value is divisible by 4 and at day 28 otherwise.
- R5: The date word layout is: day units [3:0], day tens [5:4], month units [11:8], month tens bit 12, weekday [15:13], year units [19:16], year tens [23:20]. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00. The weekday runs 1..7 and goes 7→1 on each day carry.
- R6: While `freeze`=1 the counters hold. A load (`load_en`=1 with `freeze`=1) writes the time and date words and sets the subsecond counter to `prediv`. A load with `freeze`=0 has no effect.
- R7: The shadow time, date and subsecond registers take the live values on the clock edge after each edge on which a subsecond step occurred. At all other times they hold, including across a load.
- R8: `rsf` is set on every shadow refresh. It is cleared by `rsf_clr`=1 on a cycle with no refresh; when both occur in the same cycle, the refresh wins.
- R9: With `bypass`=1, `rd_time`, `rd_date` and `rd_ss` show the live counters; with `bypass`=0 they show the shadows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaled subsecond step enable |
| freeze | input | 1 | Holds the counters and permits loads |
| load_en | input | 1 | Load strobe for time and date words |
| load_time | input | 23 | Time word to load (BCD) |
| load_date | input | 24 | Date word to load (BCD) |
| prediv | input | 15 | Subsecond reload value |
| rsf_clr | input | 1 | Clears the ready flag |
| bypass | input | 1 | Reads show live counters instead of shadows |
| rd_time | output | 23 | Time word read view |
| rd_date | output | 24 | Date word read view |
| rd_ss | output | 16 | Subsecond read view |
| rsf | output | 1 | Shadows refreshed flag |

## Verification
Reaching month, year and leap-day carries takes millions of cycles from reset. The stimulus therefore freezes the calendar, loads a time just before midnight on the date of interest, sets the reload value to 0 so that every step is a whole second, and issues one step. It then checks the rolled-over date on the live view and, one cycle later, on the shadow view. Random stretches with short reload values, sporadic freezes, random valid loads and random flag clears mix steps, captures and clears in the same cycle. A bench model predicts every value read.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int TIME_W = 23;
    localparam int DATE_W = 24;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_CAPT = 1'b1
    } sh_state_t;

    // Last day of a month as packed BCD {tens[1:0], units[3:0]}.
    function automatic logic [5:0] month_last_day(input logic [4:0] mon_bcd,
                                                  input logic [7:0] yr_bcd);
        logic [6:0] yb;
        yb = {3'b000, yr_bcd[7:4]} * 7'd10 + {3'b000, yr_bcd[3:0]};
        unique case (mon_bcd)
            5'h02:                      month_last_day = (yb[1:0] == 2'b00) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: month_last_day = 6'h30;
            default:                    month_last_day = 6'h31;
        endcase
    endfunction
endpackage

// File: rtl/cal_subsec.sv
module cal_subsec #(
    parameter int SS_W  = 16,
    parameter int PRE_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             freeze,
    input  logic             load_en,
    input  logic [PRE_W-1:0] prediv,
    output logic [SS_W-1:0]  ss,
    output logic             sec_carry
);
    logic run;
    logic do_load;

    assign run       = tick_en & ~freeze;
    assign do_load   = load_en & freeze;
    assign sec_carry = run && (ss == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss <= '0;
        end else if (do_load) begin
            ss <= SS_W'(prediv);
        end else if (run) begin
            if (ss == '0) ss <= SS_W'(prediv);
            else          ss <= ss - SS_W'(1);
        end
    end

    // R6: a frozen counter without a load keeps its value
    p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !load_en) |=> $stable(ss));

    // R2: a step from a non-zero value lowers the count by one
    p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !freeze && ss != '0) |=> (ss == $past(ss) - SS_W'(1)));
endmodule

// File: rtl/cal_tod.sv
module cal_tod
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_carry,
    input  logic              do_load,
    input  logic [TIME_W-1:0] load_word,
    output logic [TIME_W-1:0] tod,
    output logic              day_carry
);
    logic [3:0] su, mu, hu, nsu, nmu, nhu;
    logic [2:0] st, mt, nst, nmt;
    logic [1:0] ht, nht;
    logic       at_midnight;
    logic       ign_unused;

    assign ign_unused  = ^{load_word[22], load_word[15], load_word[7]};
    assign at_midnight = (su == 4'd9) && (st == 3'd5) && (mu == 4'd9) &&
                         (mt == 3'd5) && (ht == 2'd2) && (hu == 4'd3);
    assign day_carry   = sec_carry && at_midnight;
    assign tod         = {1'b0, ht, hu, 1'b0, mt, mu, 1'b0, st, su};

    always_comb begin
        {nht, nhu, nmt, nmu, nst, nsu} = {ht, hu, mt, mu, st, su};
        if (su != 4'd9) begin
            nsu = su + 4'd1;
        end else begin
            nsu = 4'd0;
            if (st != 3'd5) begin
                nst = st + 3'd1;
            end else begin
                nst = 3'd0;
                if (mu != 4'd9) begin
                    nmu = mu + 4'd1;
                end else begin
                    nmu = 4'd0;
                    if (mt != 3'd5) begin
                        nmt = mt + 3'd1;
                    end else begin
                        nmt = 3'd0;
                        if (ht == 2'd2 && hu == 4'd3) begin
                            nht = 2'd0;
                            nhu = 4'd0;
                        end else if (hu != 4'd9) begin
                            nhu = hu + 4'd1;
                        end else begin
                            nhu = 4'd0;
                            nht = ht + 2'd1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {ht, hu, mt, mu, st, su} <= '0;
        end else if (do_load) begin
            su <= load_word[3:0];
            st <= load_word[6:4];
            mu <= load_word[11:8];
            mt <= load_word[14:12];
            hu <= load_word[19:16];
            ht <= load_word[21:20];
        end else if (sec_carry) begin
            {ht, hu, mt, mu, st, su} <= {nht, nhu, nmt, nmu, nst, nsu};
        end
    end

    // R3: leaving 23:59:59 lands on 00:00:00
    p_midnight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (day_carry && !do_load) |=> (tod == '0));

    // R3: a second carry outside a load moves the seconds units
    p_sec_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_carry && !do_load) |=> (tod[3:0] != $past(tod[3:0])));
endmodule

// File: rtl/cal_date.sv
module cal_date
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              day_carry,
    input  logic              do_load,
    input  logic [DATE_W-1:0] load_word,
    output logic [DATE_W-1:0] date
);
    logic [3:0] du;
    logic [1:0] dt;
    logic [4:0] mon;
    logic [2:0] wd;
    logic [7:0] yr;
    logic [5:0] last_day;
    logic [5:0] nday;
    logic [4:0] nmon;
    logic [7:0] nyr;
    logic [2:0] nwd;
    logic       ign_unused;

    assign ign_unused = ^load_word[7:6];
    assign last_day   = month_last_day(mon, yr);
    assign date       = {yr, wd, mon, 2'b00, dt, du};

    always_comb begin
        nday = {dt, du};
        nmon = mon;
        nyr  = yr;
        nwd  = (wd == 3'd7) ? 3'd1 : wd + 3'd1;
        if ({dt, du} == last_day) begin
            nday = 6'h01;
            if (mon == 5'h12) begin
                nmon = 5'h01;
                if (yr == 8'h99)           nyr = 8'h00;
                else if (yr[3:0] == 4'd9)  nyr = {yr[7:4] + 4'd1, 4'd0};
                else                       nyr = yr + 8'd1;
            end else if (mon[3:0] == 4'd9) begin
                nmon = 5'h10;
            end else begin
                nmon = mon + 5'd1;
            end
        end else if (du == 4'd9) begin
            nday = {dt + 2'd1, 4'd0};
        end else begin
            nday = {dt, du + 4'd1};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {dt, du} <= 6'h01;
            mon      <= 5'h01;
            wd       <= 3'd1;
            yr       <= 8'h00;
        end else if (do_load) begin
            du  <= load_word[3:0];
            dt  <= load_word[5:4];
            mon <= load_word[12:8];
            wd  <= load_word[15:13];
            yr  <= load_word[23:16];
        end else if (day_carry) begin
            {dt, du} <= nday;
            mon      <= nmon;
            yr       <= nyr;
            wd       <= nwd;
        end
    end

    // R5: the weekday never shows zero
    p_wday_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !do_load |=> (date[15:13] != 3'd0));

    // R4: a day carry always changes the day field
    p_day_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (day_carry && !do_load) |=> (date[5:0] != $past(date[5:0])));
endmodule

// File: rtl/cal_shadow.sv
module cal_shadow
    import cal_pkg::*;
#(
    parameter int SS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              rsf_clr,
    input  logic              bypass,
    input  logic [TIME_W-1:0] live_time,
    input  logic [DATE_W-1:0] live_date,
    input  logic [SS_W-1:0]   live_ss,
    output logic [TIME_W-1:0] rd_time,
    output logic [DATE_W-1:0] rd_date,
    output logic [SS_W-1:0]   rd_ss,
    output logic              rsf
);
    sh_state_t         state_q, state_d;
    logic [TIME_W-1:0] sh_time;
    logic [DATE_W-1:0] sh_date;
    logic [SS_W-1:0]   sh_ss;

    always_comb begin
        unique case (state_q)
            SH_IDLE: state_d = run ? SH_CAPT : SH_IDLE;
            SH_CAPT: state_d = run ? SH_CAPT : SH_IDLE;
            default: state_d = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_time <= '0;
            sh_date <= 24'h002101;
            sh_ss   <= '0;
            rsf     <= 1'b0;
        end else if (state_q == SH_CAPT) begin
            sh_time <= live_time;
            sh_date <= live_date;
            sh_ss   <= live_ss;
            rsf     <= 1'b1;
        end else if (rsf_clr) begin
            rsf     <= 1'b0;
        end
    end

    assign rd_time = bypass ? live_time : sh_time;
    assign rd_date = bypass ? live_date : sh_date;
    assign rd_ss   = bypass ? live_ss   : sh_ss;

    // R8: the flag rises only from a capture
    p_rsf_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsf) |-> $past(state_q == SH_CAPT));

    // R8: a clear without a capture drops the flag
    p_rsf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsf_clr && state_q == SH_IDLE) |=> !rsf);

    // R7: a capture copies the live subsecond value
    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_CAPT) |=> (sh_ss == $past(live_ss)));
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int SS_W  = 16,
    parameter int PRE_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              freeze,
    input  logic              load_en,
    input  logic [TIME_W-1:0] load_time,
    input  logic [DATE_W-1:0] load_date,
    input  logic [PRE_W-1:0]  prediv,
    input  logic              rsf_clr,
    input  logic              bypass,
    output logic [TIME_W-1:0] rd_time,
    output logic [DATE_W-1:0] rd_date,
    output logic [SS_W-1:0]   rd_ss,
    output logic              rsf
);
    logic [SS_W-1:0]   live_ss;
    logic [TIME_W-1:0] live_time;
    logic [DATE_W-1:0] live_date;
    logic              sec_carry;
    logic              day_carry;
    logic              do_load;
    logic              run;

    assign do_load = load_en & freeze;
    assign run     = tick_en & ~freeze;

    cal_subsec #(.SS_W(SS_W), .PRE_W(PRE_W)) u_subsec (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze),
        .load_en(load_en), .prediv(prediv), .ss(live_ss), .sec_carry(sec_carry)
    );

    cal_tod u_tod (
        .clk(clk), .rst_n(rst_n), .sec_carry(sec_carry), .do_load(do_load),
        .load_word(load_time), .tod(live_time), .day_carry(day_carry)
    );

    cal_date u_date (
        .clk(clk), .rst_n(rst_n), .day_carry(day_carry), .do_load(do_load),
        .load_word(load_date), .date(live_date)
    );

    cal_shadow #(.SS_W(SS_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .run(run), .rsf_clr(rsf_clr), .bypass(bypass),
        .live_time(live_time), .live_date(live_date), .live_ss(live_ss),
        .rd_time(rd_time), .rd_date(rd_date), .rd_ss(rd_ss), .rsf(rsf)
    );

    // R1: the first cycle after reset shows the power-on calendar
    p_reset_state_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (live_time == '0 && live_date == 24'h002101));
endmodule

// File: tb/bcd_calendar_tb.sv
`timescale 1ns/1ps
module bcd_calendar_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, freeze = 1'b0, load_en = 1'b0;
    logic [22:0] load_time = '0;
    logic [23:0] load_date = '0;
    logic [14:0] prediv = '0;
    logic        rsf_clr = 1'b0, bypass = 1'b0;
    logic [22:0] rd_time;
    logic [23:0] rd_date;
    logic [15:0] rd_ss;
    logic        rsf;

    int total = 0, bad = 0;
    int m_sec, m_min, m_hr, m_day, m_mon, m_wd, m_yr, m_ss;
    logic [31:0] s_time, s_date, s_ss;
    bit m_rsf, cap_pend;

    always #2 clk = ~clk;

    bcd_calendar u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze),
        .load_en(load_en), .load_time(load_time), .load_date(load_date),
        .prediv(prediv), .rsf_clr(rsf_clr), .bypass(bypass),
        .rd_time(rd_time), .rd_date(rd_date), .rd_ss(rd_ss), .rsf(rsf)
    );

    function automatic logic [31:0] tw(int s, int mi, int h);
        return 32'((h / 10) << 20 | (h % 10) << 16 | (mi / 10) << 12 |
                   (mi % 10) << 8 | (s / 10) << 4 | (s % 10));
    endfunction

    function automatic logic [31:0] dw(int d, int mo, int w, int y);
        return 32'((y / 10) << 20 | (y % 10) << 16 | w << 13 |
                   (mo / 10) << 12 | (mo % 10) << 8 | (d / 10) << 4 | (d % 10));
    endfunction

    function automatic int mdays(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic adv_second();
        m_sec++;
        if (m_sec == 60) begin m_sec = 0; m_min++; end
        if (m_min == 60) begin m_min = 0; m_hr++; end
        if (m_hr == 24) begin
            m_hr = 0;
            m_day++;
            m_wd = m_wd % 7 + 1;
            if (m_day > mdays(m_mon, m_yr)) begin m_day = 1; m_mon++; end
            if (m_mon > 12) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
        end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        bypass = 1'b1;
        #0.5;
        chk({tag, " live time"}, 32'(rd_time), tw(m_sec, m_min, m_hr));
        chk({tag, " live date"}, 32'(rd_date), dw(m_day, m_mon, m_wd, m_yr));
        chk({tag, " live ss (R9)"}, 32'(rd_ss), 32'(m_ss));
        bypass = 1'b0;
        #0.5;
        chk("R7 shadow time", 32'(rd_time), s_time);
        chk("R7 shadow date", 32'(rd_date), s_date);
        chk("R7 shadow ss", 32'(rd_ss), s_ss);
        chk("R8 rsf", 32'(rsf), 32'(m_rsf));
    endtask

    // one clock: inputs applied now, model updated for the edge, checked at the falling edge
    task automatic step(bit t, bit f, bit l, bit c, int ls, int lmi, int lh,
                        int ld, int lmo, int lw, int ly, string tag);
        bit fire;
        tick_en = t; freeze = f; load_en = l; rsf_clr = c;
        load_time = 23'(tw(ls, lmi, lh));
        load_date = 24'(dw(ld, lmo, lw, ly));
        @(posedge clk);
        if (cap_pend) begin
            s_time = tw(m_sec, m_min, m_hr);
            s_date = dw(m_day, m_mon, m_wd, m_yr);
            s_ss   = 32'(m_ss);
            m_rsf  = 1'b1;
        end else if (c) begin
            m_rsf = 1'b0;
        end
        fire = t && !f;
        if (l && f) begin
            m_sec = ls; m_min = lmi; m_hr = lh;
            m_day = ld; m_mon = lmo; m_wd = lw; m_yr = ly;
            m_ss = int'(prediv);
        end else if (fire) begin
            if (m_ss == 0) begin m_ss = int'(prediv); adv_second(); end
            else m_ss--;
        end
        cap_pend = fire;
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle_step(bit t, string tag);
        step(t, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, tag);
    endtask

    // freeze and load just before a carry, then step once with prediv = 0
    task automatic roll(int s, int mi, int h, int d, int mo, int w, int y, string tag);
        prediv = '0;
        step(0, 1, 1, 0, s, mi, h, d, mo, w, y, {tag, " load (R6)"});
        idle_step(1, tag);
        idle_step(0, tag);
    endtask

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_wd = 1; m_yr = 0; m_ss = 0;
        s_time = 0; s_date = dw(1, 1, 1, 0); s_ss = 0; m_rsf = 0; cap_pend = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R2: subsecond countdown with reload 3
        prediv = 15'd3;
        for (int i = 0; i < 10; i++) idle_step(1, "R2 countdown");

        // R3: time carries
        roll(59, 59, 9, 10, 5, 3, 20, "R3 hour units");
        roll(59, 59, 19, 10, 5, 3, 20, "R3 hour tens");
        roll(59, 59, 23, 10, 5, 3, 20, "R3 midnight");
        // R4: month lengths and leap years
        roll(59, 59, 23, 28, 2, 5, 3, "R4 feb common");
        roll(59, 59, 23, 28, 2, 5, 4, "R4 feb leap 28");
        roll(59, 59, 23, 29, 2, 6, 4, "R4 feb leap 29");
        roll(59, 59, 23, 30, 4, 2, 10, "R4 april");
        roll(59, 59, 23, 31, 1, 2, 10, "R4 january");
        roll(59, 59, 23, 30, 11, 4, 10, "R4 november");
        // R5: year and weekday wraps
        roll(59, 59, 23, 31, 12, 7, 99, "R5 year wrap");
        roll(59, 59, 23, 31, 12, 3, 19, "R5 year tens");
        roll(59, 59, 23, 30, 9, 7, 19, "R5 month tens");

        // R6: load with freeze low is ignored
        step(0, 0, 1, 0, 11, 22, 13, 14, 7, 2, 44, "R6 ignored load");
        idle_step(0, "R6 ignored load");
        // R6: frozen counters hold through steps
        prediv = 15'd2;
        for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, 0, 0, 1, 1, 1, 0, "R6 frozen");
        // R8: clear then refresh with simultaneous clear
        step(0, 0, 0, 1, 0, 0, 0, 1, 1, 1, 0, "R8 clear");
        step(1, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, "R8 step");
        step(0, 0, 0, 1, 0, 0, 0, 1, 1, 1, 0, "R8 clear with refresh");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit t, f, l, c;
            int mo, yr;
            if ($urandom % 200 == 0) prediv = 15'($urandom % 5);
            t = ($urandom % 4) != 0;
            f = ($urandom % 16) == 0;
            l = f && ($urandom % 2 == 0);
            c = ($urandom % 6) == 0;
            mo = 1 + $urandom % 12;
            yr = $urandom % 100;
            step(t, f, l, c, $urandom % 60, $urandom % 60, $urandom % 24,
                 1 + $urandom % mdays(mo, yr), mo, 1 + $urandom % 7, yr, "R2 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule